// File: doc/BRIEF.md
# Vector Partial-Sum Reduction Unit

This block reduces a stream of integer elements to one wrapping sum without a single serial accumulator. A run begins with a `start` pulse that carries the element count. The block clears a row of `LANES` partial-sum registers and accepts elements over a valid/ready stream. Element k of the run is added into slot k mod `LANES`, so the input is consumed in chunks of `LANES`. A final short chunk touches only the slots it reaches.

Once the last element is accepted, a tree phase runs. On each cycle the active length halves and the upper half of the live slots is added into the lower half, with all pair additions in parallel. After log2(`LANES`) cycles slot 0 holds the total. `done` pulses for one cycle and `res_data` presents that total.

The input stream follows valid/ready rules. An element transfers only on a clock edge where `in_valid` and `in_ready` are both high. The producer may hold `in_valid` low for any number of cycles. `in_ready` is high only while elements of the current run remain to be taken. It never depends on `in_valid`.

Top module: `vec_psum_reduce`

## Requirements
- R1: During and right after reset, `in_ready` and `done` are low.
- R2: A `start` pulse seen while idle captures `len`, clears every partial sum, and raises `in_ready` from the next cycle when `len` is nonzero.
- R3: `res_data` at `done` equals the sum of the run's `len` accepted elements modulo 2^`DATA_W`, for any `len`, including values that are not multiples of `LANES`.
- R4: An element transfers only on an edge where `in_valid` and `in_ready` are both high; cycles with `in_valid` low change nothing.
- R5: After `len` elements have been accepted, `in_ready` stays low until the next run, and data offered then does not enter the sum.
- R6: `done` rises log2(`LANES`) clock edges after the edge that accepted the final element (3 edges for `LANES`=8) and is high for exactly one cycle.
- R7: With `len` = 0, `done` rises log2(`LANES`) edges after the start edge and `res_data` is 0.
- R8: A `start` pulse while a run is busy is ignored. After `done`, `res_data` holds its value until the next accepted `start`.
- R9: Each run starts from cleared partial sums, so no value from an earlier run appears in a later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, honoured only while idle |
| len | input | CNT_W | Number of elements in the run |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block will accept an element on this edge |
| in_data | input | DATA_W | Element value |
| done | output | 1 | One-cycle pulse: result available |
| res_data | output | DATA_W | Wrapping sum of the run |

## Verification
The bench targets these corner cases and the failure each one would expose:
- Lengths of 0, 1, one below, equal to and one above `LANES`. A design that mishandles the partial last chunk or the empty run returns a wrong total or a late `done`.
- Runs with random stall gaps. A design that accepts data while `in_valid` is low adds junk.
- Data offered past the run length. A design that keeps `in_ready` high after the last element would absorb that data into the total.
- A `start` pulse fired mid-run. A block that restarts on it would report a shorter sum.
- All-ones elements. These catch a width slip in the wrap.
- Back-to-back runs. These catch partial sums that were not cleared between runs.

// File: rtl/psum_pkg.sv
package psum_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_ACC, PS_TREE, PS_DONE} ps_state_e;
endpackage

// File: rtl/psum_ctrl.sv
module psum_ctrl
  import psum_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 12,
  localparam int IDX_W = $clog2(LANES),
  localparam int STEPS = $clog2(LANES),
  localparam int STEP_W = $clog2(STEPS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             take,
  output logic             clear,
  output logic [IDX_W-1:0] slot,
  output logic             tree_en,
  output logic [IDX_W:0]   half,
  output logic             done
);
  ps_state_e        state;
  logic [CNT_W-1:0] remain;
  logic [STEP_W-1:0] step;

  assign in_ready = (state == PS_ACC);
  assign take     = in_ready && in_valid;
  assign clear    = (state == PS_IDLE) && start;
  assign tree_en  = (state == PS_TREE);
  assign done     = (state == PS_DONE);
  assign half     = (IDX_W+1)'(LANES) >> (step + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PS_IDLE;
      remain <= '0;
      slot   <= '0;
      step   <= '0;
    end else begin
      unique case (state)
        PS_IDLE: if (start) begin
          remain <= len;
          slot   <= '0;
          step   <= '0;
          state  <= (len == '0) ? PS_TREE : PS_ACC;
        end
        PS_ACC: if (take) begin
          remain <= remain - 1'b1;
          slot   <= slot + 1'b1;
          if (remain == CNT_W'(1)) state <= PS_TREE;
        end
        PS_TREE: begin
          step <= step + 1'b1;
          if (step == STEP_W'(STEPS - 1)) state <= PS_DONE;
        end
        PS_DONE: state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  AST_READY_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (remain != '0)); // R5
  AST_TAKE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (remain == $past(remain) - 1'b1)); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(remain)); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACC && start && !take) |=> $stable(remain)); // R8
endmodule

// File: rtl/psum_bank.sv
module psum_bank #(
  parameter int LANES  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [IDX_W-1:0]  slot,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tree_en,
  input  logic [IDX_W:0]    half,
  output logic [DATA_W-1:0] sum0
);
  logic [DATA_W-1:0] ps [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W:0]    pidx;
    logic [DATA_W-1:0] partner;
    logic              fold;
    assign pidx    = (IDX_W+1)'(g) + half;
    assign partner = ps[pidx[IDX_W-1:0]];
    assign fold    = tree_en && ((IDX_W+1)'(g) < half);

    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        ps[g] <= '0;
      else if (take && slot == IDX_W'(g))
        ps[g] <= ps[g] + in_data;
      else if (fold)
        ps[g] <= ps[g] + partner;
    end
  end

  assign sum0 = ps[0];

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum0 == '0)); // R9
  AST_SLOT0_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == '0 && !clear) |=> (sum0 == $past(sum0) + $past(in_data))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !tree_en && !clear) |=> $stable(sum0)); // R8
endmodule

// File: rtl/vec_psum_reduce.sv
module vec_psum_reduce #(
  parameter int LANES  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic [DATA_W-1:0] res_data
);
  logic             take, clear, tree_en;
  logic [IDX_W-1:0] slot;
  logic [IDX_W:0]   half;

  psum_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .in_valid(in_valid), .in_ready(in_ready), .take(take), .clear(clear),
    .slot(slot), .tree_en(tree_en), .half(half), .done(done)
  );

  psum_bank #(.LANES(LANES), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .slot(slot),
    .in_data(in_data), .tree_en(tree_en), .half(half), .sum0(res_data)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready); // R5
  AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(res_data)); // R8
endmodule

// File: tb/vec_psum_reduce_test.sv
module vec_psum_reduce_test;
  localparam int LANES = 8;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int STEPS = $clog2(LANES);

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [CW-1:0] len = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, done;
  logic [DW-1:0] res_data;
  int n_run = 0, n_fail = 0, cycles = 0;

  always #10 clk = ~clk;

  vec_psum_reduce #(.LANES(LANES), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .done(done), .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  task automatic await_done(input logic [DW-1:0] exp, input string req);
    for (int e = 1; e <= STEPS; e++) begin
      @(negedge clk);
      if (e < STEPS) check(done == 0, "R6 early done", done, 0);
      else begin
        check(done == 1, {req, " done timing"}, done, 1);
        check(res_data == exp, {req, " sum"}, res_data, exp);
      end
    end
    @(negedge clk);
    check(done == 0, "R6 done one cycle", done, 0);
    @(negedge clk);
    check(res_data == exp, "R8 result held", res_data, exp);
  endtask

  task automatic run_case(input int n, input int gap_pct, input bit ones, input bit poke);
    logic [DW-1:0] exp = '0;
    int acc = 0;
    @(negedge clk);
    start = 1; len = CW'(n);
    @(negedge clk);
    start = 0;
    if (n == 0) begin
      check(in_ready == 0, "R7 no ready on empty run", in_ready, 0);
      await_done('0, "R7");
      return;
    end
    check(in_ready == 1, "R2 ready after start", in_ready, 1);
    while (acc < n) begin
      bit v, rdy;
      logic [DW-1:0] d;
      v = ($urandom % 100) >= gap_pct;
      d = ones ? '1 : DW'($urandom);
      in_valid = v; in_data = d;
      if (poke && acc == n / 2) begin start = 1; len = CW'(2); end
      rdy = in_ready;
      @(posedge clk);
      if (v && rdy) begin acc++; exp = wrap_add(exp, d); end
      @(negedge clk);
      start = 0;
    end
    in_valid = 1; in_data = DW'(16'h1234);
    check(in_ready == 0, "R5 ready drops after last", in_ready, 0);
    await_done(exp, "R3");
    in_valid = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check(in_ready == 0, "R1 ready in reset", in_ready, 0);
    check(done == 0, "R1 done in reset", done, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 0 && done == 0, "R1 idle after reset", {in_ready, done}, 0);
    run_case(0, 0, 0, 0);          // R7
    run_case(1, 0, 0, 0);          // R3
    run_case(LANES - 1, 0, 0, 0);  // R3 partial chunk
    run_case(LANES, 30, 0, 0);     // R4 stalls
    run_case(LANES + 1, 0, 0, 0);  // R9 fresh run
    run_case(20, 0, 1, 0);         // R3 wrap
    run_case(17, 20, 0, 1);        // R8 start while busy
    run_case(0, 0, 0, 0);          // R7 after nonzero run
    for (int r = 0; r < 12; r++) run_case(int'($urandom % 41), int'($urandom % 60), 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule